// File: doc/BRIEF.md
# Multichannel ADC conversion sequencer

This block is the digital control section of a four-channel simultaneous-sampling converter. A host loads a four-bit channel mask over a small parallel bus. A mode input chooses whether the next conversion run takes that mask or four hardware select pins. A rising edge on the start input latches the chosen mask. The block then converts the selected channels one after another, lowest index first. Each channel needs a fixed number of conversion-clock ticks, which arrive as a one-cycle enable in the system clock domain.

The analog front end is replaced by one sample word per channel, supplied at the `smp_in` port. During a run the block holds busy high and pulses an active-low end-of-conversion strobe once per channel. It stores each coded result in a slot numbered by conversion order. The host reads the results back with chip select and read low. Each completed read moves an internal slot pointer forward, and a first-slot flag shows when the pointer is at slot 0. All inputs are taken to be synchronous to `clk`.

Top module: `adc_seq_ctrl`

## Requirements
- R1: A rising edge on `conv_start` (high in a cycle after a low cycle) while idle latches the active mask and starts a run; a rising edge while `busy` is high is ignored and neither restarts nor lengthens the run.
- R2: `busy` goes high on the clock after the one that sees the `conv_start` edge, and stays high until the last selected channel is done.
- R3: Each channel takes CONV_CYC (default 14) cycles with `cvt_tick` high. `eoc_n` is low for exactly one clock at the end of each channel, and `busy` falls on the same clock as the final `eoc_n` pulse.
- R4: Channels are converted in ascending index order, and the k-th converted channel's result goes into result slot k (slot 0 first).
- R5: A rising edge of `wr_n` while `cs_n` is low and `rd_n` is high loads `db_in` into the channel register, with bit 0 selecting channel 1 and bit 3 selecting channel 4; a `wr_n` edge while `rd_n` is low changes nothing.
- R6: With `sw_mode` = 0 the run uses `hw_sel` (bit i = channel i+1); with `sw_mode` = 1 it uses the channel register.
- R7: `data_oe` is high, and `data_out` carries the slot at the pointer, on the clock after one where `cs_n` and `rd_n` are both low; otherwise `data_oe` is 0 and `data_out` is zero.
- R8: `first_data` is high exactly when the read pointer addresses slot 0; it is high after reset.
- R9: A rising edge of `rd_n` with `cs_n` low advances the pointer to the next slot, and the pointer wraps to slot 0 after the last slot filled by the latest run.
- R10: An accepted start edge resets the pointer to slot 0.
- R11: A run with an empty mask holds `busy` high for one clock and produces no `eoc_n` pulse.
- R12: With TWOS_COMP = 1 a result equals its 12-bit sample with the MSB inverted (straight binary to two's complement, 0x000 -> 0x800); with TWOS_COMP = 0 it equals the sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| conv_start | input | 1 | Conversion start, acts on its rising edge |
| cvt_tick | input | 1 | Conversion clock enable, one tick per cycle high |
| sw_mode | input | 1 | 0: hardware pins pick channels, 1: channel register does |
| hw_sel | input | 4 | Hardware channel select pins |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, acts on its rising edge |
| db_in | input | 4 | Write data for the channel register |
| smp_in | input | 48 | Per-channel 12-bit straight-binary samples, channel 1 in bits 11:0 |
| busy | output | 1 | Run in progress |
| eoc_n | output | 1 | End-of-conversion pulse, active low |
| first_data | output | 1 | Read pointer is at slot 0 |
| data_out | output | 12 | Result read data |
| data_oe | output | 1 | Read data valid (bus enable) |

## Verification
A wrong tick count or channel cursor shows at the ports as an `eoc_n` pulse on the wrong cycle, the wrong number of pulses, or a `busy` fall on the wrong cycle. All of these appear within one run of at most 56 ticks. A mis-latched mask or a wrong slot index appears only on read-back, as a result from the wrong channel in a slot. A pointer that wraps or resets wrongly shows as `first_data` at a wrong slot, or as wrong data on the read after the last slot. The random runs mix the mask source, the tick density and the sample values, so each of these faults is seen within a few runs.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_CONV,
    ST_EMPTY
  } seq_state_e;
endpackage

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
  import adc_seq_pkg::*;
#(
  parameter int NCH       = 4,
  parameter int DW        = 12,
  parameter int CONV_CYC  = 14,
  parameter bit TWOS_COMP = 1'b1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     conv_start,
  input  logic                     cvt_tick,
  input  logic [NCH-1:0]           mask_sel,
  input  logic [NCH*DW-1:0]        smp_in,
  output logic                     busy,
  output logic                     eoc_n,
  output logic                     start_acc,
  output logic [NCH-1:0]           mask_lat,
  output logic                     wr_en,
  output logic [$clog2(NCH)-1:0]   wr_slot,
  output logic [DW-1:0]            wr_data
);
  localparam int CW = $clog2(NCH);
  localparam int TW = $clog2(CONV_CYC);
  localparam logic [TW-1:0] LAST_TICK = TW'(CONV_CYC - 1);

  seq_state_e    state;
  logic          start_q;
  logic          start_edge;
  logic [TW-1:0] tick_cnt;
  logic [CW-1:0] cur_ch;
  logic [CW-1:0] slot;
  logic [CW:0]   first_hit;
  logic [CW:0]   next_hit;
  logic [DW-1:0] raw_smp;
  logic [DW-1:0] coded;

  // lowest set bit of m at index >= from; MSB of the result flags a hit
  function automatic logic [CW:0] find_ch(input logic [NCH-1:0] m, input int from);
    logic [CW:0] r;
    r = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (m[i] && (i >= from)) r = {1'b1, CW'(i)};
    end
    return r;
  endfunction

  assign start_edge = conv_start & ~start_q;
  assign start_acc  = start_edge & (state == ST_IDLE);

  always_comb begin
    first_hit = find_ch(mask_sel, 0);
    next_hit  = find_ch(mask_lat, int'(cur_ch) + 1);
    raw_smp   = smp_in[cur_ch*DW +: DW];
  end

  generate
    if (TWOS_COMP) begin : g_twos
      assign coded = {~raw_smp[DW-1], raw_smp[DW-2:0]};
    end else begin : g_straight
      assign coded = raw_smp;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      start_q  <= 1'b0;
      busy     <= 1'b0;
      eoc_n    <= 1'b1;
      tick_cnt <= '0;
      cur_ch   <= '0;
      slot     <= '0;
      mask_lat <= '0;
      wr_en    <= 1'b0;
      wr_slot  <= '0;
      wr_data  <= '0;
    end else begin
      start_q <= conv_start;
      eoc_n   <= 1'b1;
      wr_en   <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start_edge) begin
            mask_lat <= mask_sel;
            busy     <= 1'b1;
            slot     <= '0;
            tick_cnt <= '0;
            if (first_hit[CW]) begin
              cur_ch <= first_hit[CW-1:0];
              state  <= ST_CONV;
            end else begin
              state  <= ST_EMPTY;
            end
          end
        end
        ST_EMPTY: begin
          busy  <= 1'b0;
          state <= ST_IDLE;
        end
        ST_CONV: begin
          if (cvt_tick) begin
            if (tick_cnt == LAST_TICK) begin
              tick_cnt <= '0;
              eoc_n    <= 1'b0;
              wr_en    <= 1'b1;
              wr_slot  <= slot;
              wr_data  <= coded;
              slot     <= slot + 1'b1;
              if (next_hit[CW]) begin
                cur_ch <= next_hit[CW-1:0];
              end else begin
                busy  <= 1'b0;
                state <= ST_IDLE;
              end
            end else begin
              tick_cnt <= tick_cnt + 1'b1;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/adc_host_if.sv
module adc_host_if #(
  parameter int NCH = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   cs_n,
  input  logic                   rd_n,
  input  logic                   wr_n,
  input  logic [NCH-1:0]         db_in,
  input  logic                   start_acc,
  input  logic [NCH-1:0]         mask_lat,
  output logic [NCH-1:0]         chan_reg,
  output logic [$clog2(NCH)-1:0] rd_slot,
  output logic                   rd_en,
  output logic                   first_data
);
  localparam int CW = $clog2(NCH);

  logic        wr_q;
  logic        rd_q;
  logic        wr_rise;
  logic        rd_rise;
  logic [CW:0] nsel;
  logic [CW:0] ptr_inc;

  assign wr_rise    = wr_n & ~wr_q & ~cs_n & rd_n;
  assign rd_rise    = rd_n & ~rd_q & ~cs_n;
  assign nsel       = (CW+1)'($countones(mask_lat));
  assign ptr_inc    = {1'b0, rd_slot} + 1'b1;
  assign rd_en      = ~cs_n & ~rd_n;
  assign first_data = (rd_slot == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_q     <= 1'b1;
      rd_q     <= 1'b1;
      chan_reg <= '0;
      rd_slot  <= '0;
    end else begin
      wr_q <= wr_n;
      rd_q <= rd_n;
      if (wr_rise) chan_reg <= db_in;
      if (start_acc) begin
        rd_slot <= '0;
      end else if (rd_rise) begin
        if (ptr_inc >= nsel) rd_slot <= '0;
        else                 rd_slot <= ptr_inc[CW-1:0];
      end
    end
  end
endmodule

// File: rtl/adc_result_bank.sv
module adc_result_bank #(
  parameter int NCH = 4,
  parameter int DW  = 12
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_en,
  input  logic [$clog2(NCH)-1:0] wr_slot,
  input  logic [DW-1:0]          wr_data,
  input  logic                   rd_en,
  input  logic [$clog2(NCH)-1:0] rd_slot,
  output logic [DW-1:0]          data_out,
  output logic                   data_oe
);
  logic [DW-1:0] mem [NCH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_slot] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      data_out <= '0;
      data_oe  <= 1'b0;
    end else begin
      data_oe  <= rd_en;
      data_out <= rd_en ? mem[rd_slot] : '0;
    end
  end
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl #(
  parameter int NCH       = 4,
  parameter int DW        = 12,
  parameter int CONV_CYC  = 14,
  parameter bit TWOS_COMP = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              conv_start,
  input  logic              cvt_tick,
  input  logic              sw_mode,
  input  logic [NCH-1:0]    hw_sel,
  input  logic              cs_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [NCH-1:0]    db_in,
  input  logic [NCH*DW-1:0] smp_in,
  output logic              busy,
  output logic              eoc_n,
  output logic              first_data,
  output logic [DW-1:0]     data_out,
  output logic              data_oe
);
  localparam int CW = $clog2(NCH);

  logic [NCH-1:0] chan_reg;
  logic [NCH-1:0] mask_sel;
  logic [NCH-1:0] mask_lat;
  logic           start_acc;
  logic           wr_en;
  logic [CW-1:0]  wr_slot;
  logic [DW-1:0]  wr_data;
  logic [CW-1:0]  rd_slot;
  logic           rd_en;

  assign mask_sel = sw_mode ? chan_reg : hw_sel;

  adc_seq_fsm #(
    .NCH(NCH), .DW(DW), .CONV_CYC(CONV_CYC), .TWOS_COMP(TWOS_COMP)
  ) u_fsm (
    .clk(clk), .rst(rst), .conv_start(conv_start), .cvt_tick(cvt_tick),
    .mask_sel(mask_sel), .smp_in(smp_in), .busy(busy), .eoc_n(eoc_n),
    .start_acc(start_acc), .mask_lat(mask_lat), .wr_en(wr_en),
    .wr_slot(wr_slot), .wr_data(wr_data)
  );

  adc_host_if #(.NCH(NCH)) u_host (
    .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .db_in(db_in), .start_acc(start_acc), .mask_lat(mask_lat),
    .chan_reg(chan_reg), .rd_slot(rd_slot), .rd_en(rd_en),
    .first_data(first_data)
  );

  adc_result_bank #(.NCH(NCH), .DW(DW)) u_bank (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_slot(wr_slot),
    .wr_data(wr_data), .rd_en(rd_en), .rd_slot(rd_slot),
    .data_out(data_out), .data_oe(data_oe)
  );
endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk #(
  parameter int DW = 12
) (
  input logic          clk,
  input logic          rst,
  input logic          conv_start,
  input logic          busy,
  input logic          eoc_n,
  input logic          first_data,
  input logic          cs_n,
  input logic          rd_n,
  input logic          data_oe,
  input logic [DW-1:0] data_out
);
  p_busy_from_start_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(conv_start));

  p_eoc_one_clock_r3: assert property (@(posedge clk) disable iff (rst)
    !eoc_n |=> eoc_n);

  p_eoc_in_run_r3: assert property (@(posedge clk) disable iff (rst)
    !eoc_n |-> $past(busy));

  p_oe_after_read_r7: assert property (@(posedge clk) disable iff (rst)
    data_oe |-> $past(!cs_n && !rd_n));

  p_quiet_bus_r7: assert property (@(posedge clk) disable iff (rst)
    !data_oe |-> (data_out == '0));

  p_first_on_start_r10: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> first_data);
endmodule

bind adc_seq_ctrl adc_seq_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .conv_start(conv_start), .busy(busy),
  .eoc_n(eoc_n), .first_data(first_data), .cs_n(cs_n), .rd_n(rd_n),
  .data_oe(data_oe), .data_out(data_out)
);

// File: tb/test_adc_seq_ctrl.sv
module test_adc_seq_ctrl;
  localparam int NCH  = 4;
  localparam int DW   = 12;
  localparam int TC   = 14;
  localparam bit TWOS = 1'b1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic conv_start = 1'b0;
  logic cvt_tick = 1'b0;
  logic sw_mode = 1'b0;
  logic [NCH-1:0] hw_sel = '0;
  logic cs_n = 1'b1;
  logic rd_n = 1'b1;
  logic wr_n = 1'b1;
  logic [NCH-1:0] db_in = '0;
  logic [NCH*DW-1:0] smp_in = '0;
  logic busy, eoc_n, first_data, data_oe;
  logic [DW-1:0] data_out;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;
  logic [DW-1:0] smp [NCH];

  always #5 clk = ~clk;

  adc_seq_ctrl #(.NCH(NCH), .DW(DW), .CONV_CYC(TC), .TWOS_COMP(TWOS)) i_adc_seq_ctrl (
    .clk(clk), .rst(rst), .conv_start(conv_start), .cvt_tick(cvt_tick),
    .sw_mode(sw_mode), .hw_sel(hw_sel), .cs_n(cs_n), .rd_n(rd_n),
    .wr_n(wr_n), .db_in(db_in), .smp_in(smp_in), .busy(busy),
    .eoc_n(eoc_n), .first_data(first_data), .data_out(data_out),
    .data_oe(data_oe)
  );

  function automatic logic [DW-1:0] enc(input logic [DW-1:0] s);
    return TWOS ? (s ^ 12'h800) : s;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic do_write(input logic [NCH-1:0] m, input bit rd_low);
    @(negedge clk);
    cs_n = 1'b0; rd_n = rd_low ? 1'b0 : 1'b1; wr_n = 1'b0; db_in = m;
    @(negedge clk);
    wr_n = 1'b1;
    @(negedge clk);
    cs_n = 1'b1; rd_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic do_read(output logic [DW-1:0] d, output bit fd);
    @(negedge clk);
    fd = first_data;
    cs_n = 1'b0; rd_n = 1'b0;
    @(negedge clk);
    check(data_oe == 1'b1, "R7", "data_oe during read", int'(data_oe), 1);
    d = data_out;
    rd_n = 1'b1;
    @(negedge clk);
    cs_n = 1'b1;
    @(negedge clk);
    check(data_oe == 1'b0 && data_out == '0, "R7", "bus idle after read", int'(data_out), 0);
  endtask

  // run a conversion on mask m and check timing, pulses and read-back
  task automatic run_conv(input logic [NCH-1:0] m, input int pct, input bit poke,
                          input bit timing, input bit fixed);
    int nsel, cyc, ticks, eocs, first_eoc, fall_cyc;
    int order [NCH];
    logic [DW-1:0] d;
    bit fd;
    nsel = 0;
    for (int c = 0; c < NCH; c++) begin
      smp[c] = fixed ? ((c == 0) ? 12'h000 : (c == 1) ? 12'hFFF : (c == 2) ? 12'h800 : 12'h7FF)
                     : DW'($urandom);
      smp_in[c*DW +: DW] = smp[c];
      if (m[c]) begin order[nsel] = c; nsel++; end
    end
    @(negedge clk);
    conv_start = 1'b1;
    @(negedge clk);
    conv_start = 1'b0;
    check(busy == 1'b1, "R2", "busy after start edge", int'(busy), 1);
    check(first_data == 1'b1, "R10", "pointer at slot 0 on start", int'(first_data), 1);
    cyc = 0; ticks = 0; eocs = 0; first_eoc = -1; fall_cyc = -1;
    while (busy && cyc < 2000) begin
      cvt_tick = timing ? 1'b1 : (($urandom % 100) < pct);
      if (cvt_tick) ticks++;
      if (poke && cyc == 5) conv_start = 1'b1;
      if (poke && cyc == 8) conv_start = 1'b0;
      @(negedge clk);
      cyc++;
      if (!eoc_n) begin
        eocs++;
        if (first_eoc < 0) first_eoc = cyc;
      end
      if (!busy) fall_cyc = cyc;
    end
    cvt_tick = 1'b0;
    conv_start = 1'b0;
    if (nsel == 0) begin
      check(fall_cyc == 1, "R11", "empty mask busy length", fall_cyc, 1);
      check(eocs == 0, "R11", "empty mask eoc count", eocs, 0);
    end else begin
      check(eocs == nsel, "R3", "eoc pulse count", eocs, nsel);
      check(ticks == TC * nsel, "R1", "ticks spent in run", ticks, TC * nsel);
      check(!eoc_n && fall_cyc == cyc, "R3", "busy falls with last eoc", int'(eoc_n), 0);
      if (timing) begin
        check(first_eoc == TC, "R3", "first eoc cycle", first_eoc, TC);
        check(fall_cyc == TC * nsel, "R2", "busy length", fall_cyc, TC * nsel);
      end
      for (int s = 0; s < nsel; s++) begin
        do_read(d, fd);
        check(fd == (s == 0), "R8", "first_data before read", int'(fd), int'(s == 0));
        check(d == enc(smp[order[s]]), "R4", "slot result", int'(d), int'(enc(smp[order[s]])));
      end
      do_read(d, fd);
      check(fd == 1'b1, "R9", "pointer wrapped", int'(fd), 1);
      check(d == enc(smp[order[0]]), "R9", "wrap data", int'(d), int'(enc(smp[order[0]])));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL R0 watchdog expired: actual=0 expected=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(busy == 1'b0, "R2", "busy after reset", int'(busy), 0);
    check(eoc_n == 1'b1, "R3", "eoc_n after reset", int'(eoc_n), 1);
    check(first_data == 1'b1, "R8", "first_data after reset", int'(first_data), 1);
    check(data_oe == 1'b0, "R7", "data_oe after reset", int'(data_oe), 0);

    // R5 R6 R12: register write, software mode, fixed coding corners, exact timing
    do_write(4'b1010, 1'b0);
    sw_mode = 1'b1; hw_sel = 4'b0101;
    run_conv(4'b1010, 100, 1'b0, 1'b1, 1'b1);
    run_conv(4'b1010, 100, 1'b0, 1'b1, 1'b1);

    // R6 hardware pins, all four channels, coding of every corner
    do_write(4'b0001, 1'b0);
    sw_mode = 1'b0; hw_sel = 4'b1111;
    run_conv(4'b1111, 100, 1'b0, 1'b1, 1'b1);

    // R11 empty mask
    hw_sel = 4'b0000;
    run_conv(4'b0000, 100, 1'b0, 1'b0, 1'b0);

    // R5 write with rd_n low is ignored
    do_write(4'b0011, 1'b0);
    do_write(4'b1100, 1'b1);
    sw_mode = 1'b1; hw_sel = 4'b1000;
    run_conv(4'b0011, 60, 1'b0, 1'b0, 1'b0);

    // R1 start edge during busy ignored
    run_conv(4'b0011, 50, 1'b1, 1'b0, 1'b0);

    for (int it = 0; it < 24; it++) begin
      logic [NCH-1:0] m;
      m = NCH'($urandom);
      if ($urandom % 2) begin
        do_write(m, 1'b0);
        sw_mode = 1'b1; hw_sel = ~m;
      end else begin
        sw_mode = 1'b0; hw_sel = m;
      end
      run_conv(m, 30 + int'($urandom % 70), it[2], 1'b0, 1'b0);
    end

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule